// File: doc/BRIEF.md
# Triangular-Profile Fractional-N Modulus Controller

This block generates the feedback-divider control for a spread-spectrum fractional-N frequency synthesizer. It runs entirely in the oscillator clock domain. A folded up-down counter advances on a slow step strobe and produces a triangular modulation code. A first-order delta-sigma accumulator converts that code into a one-bit stream. The stream chooses, for each division cycle, whether the feedback divider counts one more or one fewer oscillator cycle than the programmable base modulus. The average divide ratio therefore sweeps up and down around the base value, which spreads the synthesized clock's spectrum.

The step strobe is a single-cycle pulse that has already been synchronized into the oscillator domain. It is normally the reference clock divided by a fixed ratio (81 by default). With the default 4-bit code, one full triangle takes 32 steps, so the modulation rate is the step rate divided by 32. The spread depends only on the code width, the accumulator width and the base modulus. The phase detector, charge pump, loop filter and oscillator lie outside this block.

Top module: `fnmod_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `tri_code` = 0, `mod_sel` = 0 and `fb_pulse` = 0, the internal accumulator and divider are cleared, and the sweep direction is set to rising.
- R2: Each clock edge with `step_en` high advances the sweep by one step. The code sequence from reset is 0,1,...,15,15,14,...,1,0,0,1,... Each end value is held for two consecutive steps, and one full triangle is 32 steps. The code register updates on the same edge that samples `step_en`.
- R3: A clock edge with `step_en` low leaves `tri_code` unchanged.
- R4: `fb_pulse` is high for exactly one clock cycle per division. The number of clock cycles from one pulse to the next equals the modulus selected at the first of those pulses: base+1 when `mod_sel` is 1, and base-1 when `mod_sel` is 0.
- R5: A 5-bit accumulator starts at 0 after reset. On each edge where `fb_pulse` rises, the accumulator adds the zero-extended `tri_code` value that was present before that edge. `mod_sel` becomes the carry out of that addition (1 when the sum reaches 32) and holds until the next pulse.
- R6: With `tri_code` at 0, every division uses base-1 and `mod_sel` stays 0.
- R7: With `tri_code` held at a constant value c, any 32 consecutive divisions contain exactly c selections of base+1.
- R8: `base_mod` is sampled only when the divider reloads. A change made during a division affects the next division, not the current one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Single-cycle sweep step strobe, already synchronized to `clk` |
| base_mod | input | MOD_W (12) | Base divide modulus N (must be at least 3) |
| fb_pulse | output | 1 | One-cycle divider feedback pulse |
| mod_sel | output | 1 | Modulus select for the current division (1 = N+1, 0 = N-1) |
| tri_code | output | CODE_W (4) | Current triangular modulation code |

## Verification
A wrong fold or direction state in the sweep counter appears on `tri_code` at the first step that reaches either end of the triangle, one cycle after the strobe. A corrupted accumulator does not produce a wrong interval at once. It shifts the carry pattern, so `mod_sel` differs from an independent model at the next pulse, and the count of base+1 selections in a 32-division window drifts away from the code value. A divider reload error shows in the very next interval between pulses, which is off by one or two cycles from the selected modulus.

// File: rtl/fnmod_pkg.sv
package fnmod_pkg;
  typedef enum logic {
    SWEEP_RISE = 1'b0,
    SWEEP_FALL = 1'b1
  } sweep_dir_e;

  function automatic sweep_dir_e dir_of(input logic msb);
    return msb ? SWEEP_FALL : SWEEP_RISE;
  endfunction
endpackage

// File: rtl/fnmod_sweep.sv
module fnmod_sweep #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  output logic [CODE_W-1:0] code_q
);
  import fnmod_pkg::*;

  localparam int PH_W = CODE_W + 1;

  logic [PH_W-1:0]   phase_q;
  logic [PH_W-1:0]   phase_nxt;
  logic [CODE_W-1:0] code_nxt;
  sweep_dir_e        dir_nxt;

  always_comb begin
    phase_nxt = phase_q + PH_W'(1);
    dir_nxt   = dir_of(phase_nxt[PH_W-1]);
    if (dir_nxt == SWEEP_FALL) code_nxt = ~phase_nxt[CODE_W-1:0];
    else                       code_nxt =  phase_nxt[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      code_q  <= '0;
    end else if (step_en) begin
      phase_q <= phase_nxt;
      code_q  <= code_nxt;
    end
  end
endmodule

// File: rtl/fnmod_dsm.sv
module fnmod_dsm #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [CODE_W-1:0] code,
  output logic              carry_nxt,
  output logic              sel_q
);
  localparam int ACC_W = CODE_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum       = {1'b0, acc_q} + (ACC_W + 1)'(code);
    carry_nxt = sum[ACC_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      sel_q <= 1'b0;
    end else if (fire) begin
      acc_q <= sum[ACC_W-1:0];
      sel_q <= carry_nxt;
    end
  end
endmodule

// File: rtl/fnmod_div.sv
module fnmod_div #(
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MOD_W-1:0] base,
  input  logic             wide_sel,
  output logic             term,
  output logic             pulse_q
);
  logic [MOD_W-1:0] cnt_q;
  logic [MOD_W-1:0] reload;

  always_comb begin
    term   = (cnt_q == '0);
    // selected modulus minus one: N for N+1, N-2 for N-1
    reload = wide_sel ? base : base - MOD_W'(2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (term) begin
      cnt_q   <= reload;
      pulse_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_q - MOD_W'(1);
      pulse_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fnmod_ctrl.sv
module fnmod_ctrl #(
  parameter int CODE_W = 4,
  parameter int MOD_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic [MOD_W-1:0]  base_mod,
  output logic              fb_pulse,
  output logic              mod_sel,
  output logic [CODE_W-1:0] tri_code
);
  logic term;
  logic carry_nxt;

  fnmod_sweep #(.CODE_W(CODE_W)) u_sweep (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .code_q  (tri_code)
  );

  fnmod_dsm #(.CODE_W(CODE_W)) u_dsm (
    .clk       (clk),
    .rst       (rst),
    .fire      (term),
    .code      (tri_code),
    .carry_nxt (carry_nxt),
    .sel_q     (mod_sel)
  );

  fnmod_div #(.MOD_W(MOD_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .base     (base_mod),
    .wide_sel (carry_nxt),
    .term     (term),
    .pulse_q  (fb_pulse)
  );
endmodule

// File: rtl/fnmod_ctrl_chk.sv
module fnmod_ctrl_chk #(
  parameter int CODE_W = 4,
  parameter int MOD_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              step_en,
  input logic [MOD_W-1:0]  base_mod,
  input logic              fb_pulse,
  input logic              mod_sel,
  input logic [CODE_W-1:0] tri_code
);
  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (tri_code == '0) && !mod_sel && !fb_pulse);

  // R3: code holds without a step
  a_r3_hold_code: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(tri_code));

  // R2: a step moves the code by at most one
  a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
    step_en |=> ($stable(tri_code)
                 || (tri_code == $past(tri_code) + CODE_W'(1))
                 || (tri_code + CODE_W'(1) == $past(tri_code))));

  // R4: pulse lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> !fb_pulse);

  // R5: selection changes only together with a pulse
  a_r5_sel_on_pulse: assert property (@(posedge clk) disable iff (rst)
    !fb_pulse |-> $stable(mod_sel));
endmodule

bind fnmod_ctrl fnmod_ctrl_chk #(.CODE_W(CODE_W), .MOD_W(MOD_W)) u_chk (.*);

// File: tb/test_fnmod_ctrl.sv
module test_fnmod_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b0;
  logic [11:0] base_mod = 12'd10;
  logic        fb_pulse;
  logic        mod_sel;
  logic [3:0]  tri_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fnmod_ctrl i_fnmod_ctrl (
    .clk(clk), .rst(rst), .step_en(step_en), .base_mod(base_mod),
    .fb_pulse(fb_pulse), .mod_sel(mod_sel), .tri_code(tri_code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // independent model of accumulator and interval
  int         acc_m = 0;
  int         cnt_m = 0;
  int         exp_int = 0;
  bit         have_last = 0;
  bit         pulse_prev = 0;
  logic [3:0]  code_prev = '0;
  logic [11:0] base_prev = '0;

  always @(negedge clk) begin
    if (rst) begin
      acc_m = 0; cnt_m = 0; have_last = 0; pulse_prev = 0;
    end else begin
      cnt_m++;
      if (fb_pulse) begin
        bit carry;
        chk(!pulse_prev, "R4 pulse width", 2, 1);
        acc_m = acc_m + int'(code_prev);
        carry = (acc_m >= 32);
        acc_m = acc_m % 32;
        chk(mod_sel == carry, "R5 mod_sel carry", int'(mod_sel), int'(carry));
        if (have_last) chk(cnt_m == exp_int, "R4 interval", cnt_m, exp_int);
        exp_int = carry ? int'(base_prev) + 1 : int'(base_prev) - 1;
        cnt_m = 0;
        have_last = 1;
      end
      pulse_prev = fb_pulse;
    end
    code_prev = tri_code;
    base_prev = base_mod;
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2 step_en = 1'b1;
      @(posedge clk); #2 step_en = 1'b0;
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!fb_pulse);
  endtask

  // {steps to issue, expected code afterwards}
  localparam logic [11:0] VEC [7] = '{
    {8'd5,  4'd5}, {8'd10, 4'd15}, {8'd1, 4'd15}, {8'd1, 4'd14},
    {8'd14, 4'd0}, {8'd1,  4'd0},  {8'd1, 4'd1}
  };

  initial begin
    int lim = 0;
    while (!done) begin
      @(posedge clk);
      lim++;
      if (lim > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", lim, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n, sel, wides;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(tri_code == 0, "R1 reset code", tri_code, 0);
    chk(mod_sel == 0, "R1 reset mod_sel", mod_sel, 0);
    chk(fb_pulse == 0, "R1 reset fb_pulse", fb_pulse, 0);
    @(posedge clk); #2 rst = 1'b0;

    // R6: code 0 keeps narrow modulus
    for (int i = 0; i < 10; i++) begin
      wait_pulse();
      chk(mod_sel == 0, "R6 code zero mod_sel", mod_sel, 0);
    end

    // R2: triangle sequence table
    for (int v = 0; v < 7; v++) begin
      step(int'(VEC[v][11:4]));
      @(negedge clk);
      chk(tri_code == VEC[v][3:0], "R2 triangle code", tri_code, VEC[v][3:0]);
    end

    // R3: no strobe, no change
    repeat (20) @(negedge clk);
    chk(tri_code == 4'd1, "R3 hold code", tri_code, 1);

    // R7: exact count of wide selections, code 5 then 15
    step(4);
    wait_pulse();
    wides = 0;
    for (int i = 0; i < 32; i++) begin wait_pulse(); wides += int'(mod_sel); end
    chk(wides == 5, "R7 count code 5", wides, 5);
    step(10);
    wait_pulse();
    wides = 0;
    for (int i = 0; i < 32; i++) begin wait_pulse(); wides += int'(mod_sel); end
    chk(wides == 15, "R7 count code 15", wides, 15);

    // R8: base change applies at the next reload
    wait_pulse();
    sel = int'(mod_sel);
    base_mod = 12'd14;
    n = 0;
    do begin @(negedge clk); n++; end while (!fb_pulse);
    chk(n == (sel ? 11 : 9), "R8 current division old base", n, sel ? 11 : 9);
    sel = int'(mod_sel);
    n = 0;
    do begin @(negedge clk); n++; end while (!fb_pulse);
    chk(n == (sel ? 15 : 13), "R8 next division new base", n, sel ? 15 : 13);

    // R1: reset in the middle of operation
    @(posedge clk); #2 rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(tri_code == 0, "R1 mid-run reset code", tri_code, 0);
    chk(mod_sel == 0, "R1 mid-run reset mod_sel", mod_sel, 0);
    chk(fb_pulse == 0, "R1 mid-run reset fb_pulse", fb_pulse, 0);
    @(posedge clk); #2 rst = 1'b0;
    step(1);
    @(negedge clk);
    chk(tri_code == 1, "R1 direction rising after reset", tri_code, 1);
    repeat (40) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule